// File: doc/BRIEF.md
# Indexed-Colour Palette with Host Register Window

This block holds the colour lookup table of an indexed-colour display. It has 256 main entries, which the pixel stream uses, and 4 overlay entries, which the cursor uses. Each entry holds an 8-bit red, green and blue value. The host reaches the table through a four-word register window. One word loads an entry pointer. Two words write colour components into the main bank or the overlay bank. Each colour is moved as three single-byte accesses, always in red, green, blue order. The third access moves the pointer to the next entry.

The display pipeline reads the table through its own port, which is separate from the host window. It presents an entry number from 0 to 259 and gets the packed `{R,G,B}` value one cycle later. Host reads travel as a one-cycle data pulse, `host_rvalid`, on the cycle after the access. There is no ready signal, so the host cannot apply back-pressure and must take the data in that cycle. All host-side control inputs are plain level signals, sampled on the clock edge.

Top module: `palette_regs`

## Requirements
- R1: A write with `host_sel`=0 loads the entry pointer from `host_wdata[31:24]` and sets the component phase to red. This holds even in the middle of a colour.
- R2: Writes with `host_sel`=1 store `host_wdata[31:24]` into main entry [pointer]. Successive writes fill red, then green, then blue, and bits 23:0 are ignored.
- R3: Writes with `host_sel`=3 store into overlay entry 256 + (pointer mod 4), using the same red, green, blue phase sequence as R2.
- R4: After the blue access the phase returns to red and the pointer increments, wrapping from 255 to 0. The red and green accesses leave the pointer unchanged.
- R5: A read (`host_en`=1, `host_wr`=0, any `host_sel`) returns the current-phase component of main entry [pointer] in bits 31:24, with bits 23:0 zero. The data arrives with `host_rvalid` high on the next cycle. Reads step the phase and pointer exactly as writes do.
- R6: After reset, every entry is black except entries 255, 256 and 258, which are white (`24'hFFFFFF`). The pointer is 0, the phase is red and `host_rvalid` is low.
- R7: A write with `host_sel`=2 changes no entry, and changes neither the phase nor the pointer.
- R8: `disp_rgb` presents `{R,G,B}` of entry `disp_idx` one cycle after `disp_idx` is applied. An entry number of 260 or above returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_en | input | 1 | Host access strobe, one access per cycle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_sel | input | 2 | Word select: 0 pointer, 1 main colour, 2 spare, 3 overlay colour |
| host_wdata | input | 32 | Write data; the byte in bits 31:24 is used |
| host_rdata | output | 32 | Read component in bits 31:24, zero below |
| host_rvalid | output | 1 | Read data valid pulse, one cycle after a read |
| disp_idx | input | 9 | Display lookup entry number |
| disp_rgb | output | 24 | Display lookup result `{R,G,B}` |

## Verification
The faults this block can hide are a wrong pointer and a wrong phase. A slipped phase puts the next colour's bytes in the wrong component, so the next display lookup of that entry shows it. A pointer that steps early, late or not at all puts the next colour in the wrong entry. In every read sequence, the phase error appears by the second byte returned, at most two cycles after it happens.

// File: rtl/pal_pkg.sv
package pal_pkg;

  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_t;

  typedef enum logic [1:0] {
    SEL_INDEX   = 2'd0,
    SEL_MAIN    = 2'd1,
    SEL_SPARE   = 2'd2,
    SEL_OVERLAY = 2'd3
  } sel_t;

  // Reset colour: the last main entry, the first overlay and the third
  // overlay come up white, the rest black.
  function automatic logic [23:0] reset_colour(int unsigned ent, int unsigned n_main);
    if (ent == n_main - 1 || ent == n_main || ent == n_main + 2)
      return 24'hFFFFFF;
    return 24'h000000;
  endfunction

endpackage

// File: rtl/pal_seq.sv
module pal_seq
  import pal_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_en,
  input  logic             acc_wr,
  input  sel_t             acc_sel,
  input  logic [IDX_W-1:0] load_val,
  output logic [IDX_W-1:0] idx,
  output phase_t           phase
);

  logic load, step;

  assign load = acc_en && acc_wr && (acc_sel == SEL_INDEX);
  assign step = acc_en && (!acc_wr || acc_sel == SEL_MAIN || acc_sel == SEL_OVERLAY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx   <= '0;
      phase <= PH_RED;
    end else if (load) begin
      idx   <= load_val;
      phase <= PH_RED;
    end else if (step) begin
      unique case (phase)
        PH_RED:  phase <= PH_GRN;
        PH_GRN:  phase <= PH_BLU;
        default: begin
          phase <= PH_RED;
          idx   <= idx + 1'b1;
        end
      endcase
    end
  end

  // R1: pointer load resets the phase
  a_r1_index_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (idx == $past(load_val)) && (phase == PH_RED));

  // R4: blue access advances the pointer with wrap
  a_r4_blue_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (step && phase == PH_BLU) |=> (idx == IDX_W'($past(idx) + 1)) && (phase == PH_RED));

  // R4: red and green accesses hold the pointer
  a_r4_hold_idx: assert property (@(posedge clk) disable iff (!rst_n)
    (step && phase != PH_BLU) |=> $stable(idx));

  // R7: spare-word writes disturb nothing
  a_r7_spare_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_wr && acc_sel == SEL_SPARE) |=> $stable(idx) && $stable(phase));

  // R4: phase stays in its three legal states
  a_r4_phase_legal: assert property (@(posedge clk) disable iff (!rst_n)
    2'(phase) != 2'd3);

endmodule

// File: rtl/pal_store.sv
module pal_store
  import pal_pkg::*;
#(
  parameter int N_MAIN = 256,
  parameter int N_ENT  = 260,
  parameter int ENT_W  = 9,
  parameter int COMP_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ENT_W-1:0]    wr_ent,
  input  phase_t              wr_comp,
  input  logic [COMP_W-1:0]   wr_byte,
  input  logic                rd_en,
  input  logic [ENT_W-1:0]    rd_ent,
  input  phase_t              rd_comp,
  output logic [COMP_W-1:0]   rd_byte,
  output logic                rd_valid,
  input  logic [ENT_W-1:0]    disp_ent,
  output logic [3*COMP_W-1:0] disp_rgb
);

  localparam int RGB_W = 3 * COMP_W;

  logic [RGB_W-1:0] table_q [N_ENT];

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    localparam logic [RGB_W-1:0] RST = RGB_W'(reset_colour(e, N_MAIN));
    logic [RGB_W-1:0] rgb_q;
    logic             hit;

    assign hit = wr_en && (wr_ent == ENT_W'(e));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rgb_q <= RST;
      end else if (hit) begin
        unique case (wr_comp)
          PH_RED:  rgb_q[RGB_W-1 -: COMP_W]    <= wr_byte;
          PH_GRN:  rgb_q[2*COMP_W-1 -: COMP_W] <= wr_byte;
          default: rgb_q[COMP_W-1:0]           <= wr_byte;
        endcase
      end
    end

    assign table_q[e] = rgb_q;
  end

  logic [RGB_W-1:0] rd_rgb;
  assign rd_rgb = (rd_ent < ENT_W'(N_ENT)) ? table_q[rd_ent] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_byte  <= '0;
      disp_rgb <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        unique case (rd_comp)
          PH_RED:  rd_byte <= rd_rgb[RGB_W-1 -: COMP_W];
          PH_GRN:  rd_byte <= rd_rgb[2*COMP_W-1 -: COMP_W];
          default: rd_byte <= rd_rgb[COMP_W-1:0];
        endcase
      end
      disp_rgb <= (disp_ent < ENT_W'(N_ENT)) ? table_q[disp_ent] : '0;
    end
  end

  // R8: entry numbers beyond the table read as zero
  a_r8_disp_range: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_ent >= ENT_W'(N_ENT)) |=> (disp_rgb == '0));

endmodule

// File: rtl/palette_regs.sv
module palette_regs
  import pal_pkg::*;
#(
  parameter int MAIN_ENTRIES = 256,
  parameter int OVL_ENTRIES  = 4,
  parameter int COMP_W       = 8,
  parameter int DATA_W       = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_en,
  input  logic                 host_wr,
  input  logic [1:0]           host_sel,
  input  logic [DATA_W-1:0]    host_wdata,
  output logic [DATA_W-1:0]    host_rdata,
  output logic                 host_rvalid,
  input  logic [ENT_W-1:0]     disp_idx,
  output logic [3*COMP_W-1:0]  disp_rgb
);

  localparam int IDX_W   = $clog2(MAIN_ENTRIES);
  localparam int OVL_W   = $clog2(OVL_ENTRIES);
  localparam int N_ENT   = MAIN_ENTRIES + OVL_ENTRIES;
  localparam int ENT_W   = $clog2(N_ENT);
  localparam int LOW_W   = DATA_W - COMP_W;

  sel_t             sel;
  logic [IDX_W-1:0] idx;
  phase_t           phase;
  logic             wr_en, rd_en;
  logic [ENT_W-1:0] wr_ent;
  logic [COMP_W-1:0] rd_byte;

  assign sel = sel_t'(host_sel);

  pal_seq #(.IDX_W(IDX_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_en   (host_en),
    .acc_wr   (host_wr),
    .acc_sel  (sel),
    .load_val (host_wdata[DATA_W-1 -: IDX_W]),
    .idx      (idx),
    .phase    (phase)
  );

  assign wr_en  = host_en && host_wr && (sel == SEL_MAIN || sel == SEL_OVERLAY);
  assign rd_en  = host_en && !host_wr;
  assign wr_ent = (sel == SEL_OVERLAY)
                ? ENT_W'(MAIN_ENTRIES) + ENT_W'(idx[OVL_W-1:0])
                : ENT_W'(idx);

  pal_store #(
    .N_MAIN (MAIN_ENTRIES),
    .N_ENT  (N_ENT),
    .ENT_W  (ENT_W),
    .COMP_W (COMP_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_ent   (wr_ent),
    .wr_comp  (phase),
    .wr_byte  (host_wdata[DATA_W-1 -: COMP_W]),
    .rd_en    (rd_en),
    .rd_ent   (ENT_W'(idx)),
    .rd_comp  (phase),
    .rd_byte  (rd_byte),
    .rd_valid (host_rvalid),
    .disp_ent (disp_idx),
    .disp_rgb (disp_rgb)
  );

  assign host_rdata = {rd_byte, {LOW_W{1'b0}}};

  // R5: read data arrives exactly one cycle after a read access
  a_r5_rvalid_timing: assert property (@(posedge clk) disable iff (!rst_n)
    (host_en && !host_wr) |=> host_rvalid);

  // R5: no data pulse without a read
  a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_en && !host_wr) |=> !host_rvalid);

endmodule

// File: tb/palette_regs_tb.sv
module palette_regs_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_en = 1'b0, host_wr = 1'b0;
  logic [1:0]  host_sel = 2'd0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_rvalid;
  logic [8:0]  disp_idx = '0;
  logic [23:0] disp_rgb;

  always #2 clk = ~clk;

  palette_regs u_dut (
    .clk(clk), .rst_n(rst_n), .host_en(host_en), .host_wr(host_wr),
    .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .disp_idx(disp_idx), .disp_rgb(disp_rgb)
  );

  int errors = 0, checks = 0;
  logic [23:0] m [260];
  logic [7:0]  midx;
  int          mph;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 260; i++)
      m[i] = (i == 255 || i == 256 || i == 258) ? 24'hFFFFFF : 24'h0;
    midx = 0;
    mph  = 0;
  endtask

  function automatic logic [7:0] comp_of(logic [23:0] c, int ph);
    return (ph == 0) ? c[23:16] : (ph == 1) ? c[15:8] : c[7:0];
  endfunction

  task automatic model_step();
    if (mph == 2) begin mph = 0; midx = midx + 8'd1; end
    else mph++;
  endtask

  // Driver: one host access per cycle; reads push expectations.
  task automatic acc(bit wr, logic [1:0] sel, logic [7:0] b, string tag);
    int ent;
    @(negedge clk);
    host_en = 1'b1; host_wr = wr; host_sel = sel;
    host_wdata = {b, 24'hA5C3E1};
    if (!wr) begin
      exp_q.push_back({comp_of(m[midx], mph), 24'h0});
      tag_q.push_back(tag);
      model_step();
    end else if (sel == 2'd0) begin
      midx = b; mph = 0;
    end else if (sel == 2'd1 || sel == 2'd3) begin
      ent = (sel == 2'd3) ? 256 + int'(midx[1:0]) : int'(midx);
      if (mph == 0) m[ent][23:16] = b;
      else if (mph == 1) m[ent][15:8] = b;
      else m[ent][7:0] = b;
      model_step();
    end
  endtask

  task automatic idle();
    @(negedge clk);
    host_en = 1'b0; host_wr = 1'b0;
  endtask

  task automatic chk_disp(int ent, string tag);
    logic [23:0] e;
    idle();
    disp_idx = 9'(ent);
    e = (ent < 260) ? m[ent] : 24'h0;
    @(negedge clk);
    check(disp_rgb == e, tag, {8'h0, disp_rgb}, {8'h0, e});
  endtask

  // Monitor: pops the scoreboard when read data appears.
  always @(negedge clk) begin
    if (rst_n && host_rvalid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5 unexpected rvalid", host_rdata, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(host_rdata == e, t, host_rdata, e);
      end
    end
  end

  bit done = 1'b0;
  initial begin
    #(4 * 200000);
    if (!done) begin
      check(1'b0, "watchdog", 32'h0, 32'h1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(host_rvalid == 1'b0, "R6 rvalid idle", {31'h0, host_rvalid}, 32'h0);
    chk_disp(255, "R6 entry 255 white");
    chk_disp(256, "R6 entry 256 white");
    chk_disp(257, "R6 entry 257 black");
    chk_disp(258, "R6 entry 258 white");
    chk_disp(0,   "R6 entry 0 black");
    // R6/R5: reading entry 0 after reset
    acc(0, 2'd1, 8'h0, "R6 read r0");
    acc(0, 2'd2, 8'h0, "R5 read g0");
    acc(0, 2'd0, 8'h0, "R5 read b0");
    idle();
    // R1/R2: load pointer, write two colours back to back
    acc(1, 2'd0, 8'd10, "R1");
    acc(1, 2'd1, 8'h11, "R2");
    acc(1, 2'd1, 8'h22, "R2");
    acc(1, 2'd1, 8'h33, "R2");
    acc(1, 2'd1, 8'h44, "R4");
    acc(1, 2'd1, 8'h55, "R4");
    acc(1, 2'd1, 8'h66, "R4");
    chk_disp(10, "R2 entry 10");
    chk_disp(11, "R4 auto-increment entry 11");
    // R5: read both back
    acc(1, 2'd0, 8'd10, "R1");
    for (int k = 0; k < 6; k++) acc(0, 2'd1, 8'h0, "R5 readback");
    idle();
    // R3: overlay write with pointer 6 -> entry 258
    acc(1, 2'd0, 8'd6, "R1");
    acc(1, 2'd3, 8'h12, "R3");
    acc(1, 2'd3, 8'h34, "R3");
    acc(1, 2'd3, 8'h56, "R3");
    chk_disp(258, "R3 overlay 258");
    chk_disp(6,   "R3 main entry 6 untouched");
    // R7: spare write between components
    acc(1, 2'd0, 8'd20, "R1");
    acc(1, 2'd1, 8'h70, "R7");
    acc(1, 2'd2, 8'hEE, "R7");
    acc(1, 2'd1, 8'h71, "R7");
    acc(1, 2'd2, 8'hEE, "R7");
    acc(1, 2'd1, 8'h72, "R7");
    chk_disp(20, "R7 spare write no effect");
    chk_disp(21, "R7 next entry unchanged");
    // R1: pointer reload mid-colour resets phase
    acc(1, 2'd0, 8'd30, "R1");
    acc(1, 2'd1, 8'hAA, "R1");
    acc(1, 2'd0, 8'd31, "R1");
    acc(1, 2'd1, 8'h01, "R1");
    acc(1, 2'd1, 8'h02, "R1");
    acc(1, 2'd1, 8'h03, "R1");
    chk_disp(30, "R1 partial entry 30");
    chk_disp(31, "R1 phase reset entry 31");
    // R4: wrap from 255 to 0
    acc(1, 2'd0, 8'd255, "R1");
    acc(1, 2'd1, 8'h0F, "R4");
    acc(1, 2'd1, 8'h1F, "R4");
    acc(1, 2'd1, 8'h2F, "R4");
    acc(1, 2'd1, 8'h9C, "R4 wrap");
    chk_disp(255, "R4 entry 255");
    chk_disp(0,   "R4 wrapped to entry 0");
    // R5: read wrap from 255 to 0
    acc(1, 2'd0, 8'd255, "R1");
    for (int k = 0; k < 4; k++) acc(0, 2'd3, 8'h0, "R5 read wrap");
    idle();
    // R8: out-of-range display lookups
    chk_disp(259, "R8 entry 259");
    chk_disp(300, "R8 out of range");
    chk_disp(511, "R8 out of range");
    idle();
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R5 all reads returned", 32'(exp_q.size()), 32'h0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule